// File: doc/BRIEF.md
# Paired-Slice Distributed Dual-Port RAM

This block is a 16-word by 2-bit memory built from lookup-table storage cells, each cell holding 16 one-bit words. In its single-port build, one slice of two cells serves as the whole RAM. The two cells sit side by side, one per data bit, and share one address for the synchronous write and the asynchronous read.

In its dual-port build, a second slice is paired with the first. The primary slice owns the read-write port. The companion slice receives every write at the same edge and keeps a mirror of the contents. It serves a read-only port at an independent address. A parameter chooses the build. In the single-port build the read-only outputs are held at zero.

Memory contents are undefined after power-up; a user writes a location before reading it. The reset input blocks writes while it is high and clears nothing.

Top module: `dist_dpram`

## Requirements
- R1: On a rising clock edge with `wr_en` high and `rst` low, the 2-bit `wr_data` is stored at word `rw_addr` (16 words, addresses 0 to 15).
- R2: `rw_rdata` shows the word at `rw_addr` combinationally, with no clock edge between an address change and the new data.
- R3: With `DUAL_PORT` = 1, `ro_rdata` shows the word at `ro_addr` combinationally, and `ro_addr` is independent of `rw_addr`.
- R4: Every write updates the primary and the companion copy at the same edge, so both ports give equal data whenever they point at the same address.
- R5: When `ro_addr` equals the address being written, `ro_rdata` shows the old word before the write edge and the new word after it.
- R6: A write changes only the addressed word; every other word keeps its value on both ports.
- R7: On an edge with `wr_en` low, no word changes.
- R8: On an edge with `rst` high, no word changes even if `wr_en` is high.
- R9: With `DUAL_PORT` = 0, `ro_rdata` is always 0 and the read-write port still behaves as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| rst | input | 1 | Synchronous active-high write block |
| wr_en | input | 1 | Write enable |
| rw_addr | input | 4 | Address of the read-write port |
| wr_data | input | 2 | Data to write |
| rw_rdata | output | 2 | Asynchronous read data at `rw_addr` |
| ro_addr | input | 4 | Address of the read-only port |
| ro_rdata | output | 2 | Asynchronous read data at `ro_addr` (zero in single-port build) |

## Verification
The memory is first filled with every address written once. The read-only port follows the written address during the fill, which separates old data before the edge from new data after it. Opposite-order sweeps of the two addresses with writes off show that the ports decode on their own and are not tied together. Targeted writes then exercise a write at one address while the other port watches a different one, and writes attempted with the enable low or with reset high. A long pseudo-random run compares both ports against a behavioural model before and after every edge. A single-port instance driven by the same stimulus shows a working read-write port and a read-only output that stays at zero.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    localparam int MEM_ADDR_W = 4;
    localparam int MEM_DATA_W = 2;
    localparam int MEM_DEPTH  = 1 << MEM_ADDR_W;

    typedef logic [MEM_ADDR_W-1:0] addr_t;
    typedef logic [MEM_DATA_W-1:0] word_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    function automatic wr_req_t pack_write(input logic en, input addr_t a, input word_t d);
        wr_req_t r;
        r.en   = en;
        r.addr = a;
        r.data = d;
        return r;
    endfunction
endpackage

// File: rtl/lut_cell.sv
module lut_cell #(
    parameter int ADDR_W = dpram_pkg::MEM_ADDR_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              d,
    input  logic [ADDR_W-1:0] raddr,
    output logic              q
);
    logic [DEPTH-1:0] bits;

    always_ff @(posedge clk) begin
        if (we) begin
            bits[waddr] <= d;
        end
    end

    assign q = bits[raddr];
endmodule

// File: rtl/mem_slice.sv
module mem_slice
    import dpram_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  addr_t   raddr,
    output word_t   rdata
);
    logic we_eff;
    assign we_eff = req.en & ~rst;

    for (genvar b = 0; b < MEM_DATA_W; b++) begin : g_bit
        lut_cell #(.ADDR_W(MEM_ADDR_W)) u_cell (
            .clk   (clk),
            .we    (we_eff),
            .waddr (req.addr),
            .d     (req.data[b]),
            .raddr (raddr),
            .q     (rdata[b])
        );
    end

    // R1
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req.en && !rst) && raddr == $past(req.addr)) |-> rdata == $past(req.data));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(req.en) && !$past(rst) && raddr == $past(raddr)) |-> rdata == $past(rdata));
endmodule

// File: rtl/dist_dpram.sv
module dist_dpram
    import dpram_pkg::*;
#(
    parameter bit DUAL_PORT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [MEM_ADDR_W-1:0] rw_addr,
    input  logic [MEM_DATA_W-1:0] wr_data,
    output logic [MEM_DATA_W-1:0] rw_rdata,
    input  logic [MEM_ADDR_W-1:0] ro_addr,
    output logic [MEM_DATA_W-1:0] ro_rdata
);
    wr_req_t req;
    assign req = pack_write(wr_en, rw_addr, wr_data);

    mem_slice u_primary (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .raddr (rw_addr),
        .rdata (rw_rdata)
    );

    if (DUAL_PORT) begin : g_dual
        mem_slice u_companion (
            .clk   (clk),
            .rst   (rst),
            .req   (req),
            .raddr (ro_addr),
            .rdata (ro_rdata)
        );

        // R4
        mirror_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en && !rst) && ro_addr == rw_addr && ro_addr == $past(rw_addr))
            |-> ro_rdata == rw_rdata);

        // R6
        other_word_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en) && ro_addr != $past(rw_addr) && ro_addr == $past(ro_addr) && !$past(rst))
            |-> ro_rdata == $past(ro_rdata));
    end else begin : g_single
        assign ro_rdata = '0;
    end
endmodule

// File: tb/dist_dpram_bench.sv
module dist_dpram_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] rw_addr = '0;
    logic [1:0] wr_data = '0;
    logic [3:0] ro_addr = '0;
    logic [1:0] rw_rdata, ro_rdata, sp_rw_rdata, sp_ro_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0] model [16];
    bit         valid [16];
    logic [31:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    dist_dpram #(.DUAL_PORT(1'b1)) u_dist_dpram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rw_addr(rw_addr), .wr_data(wr_data),
        .rw_rdata(rw_rdata), .ro_addr(ro_addr), .ro_rdata(ro_rdata));

    dist_dpram #(.DUAL_PORT(1'b0)) u_dist_dpram_sp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rw_addr(rw_addr), .wr_data(wr_data),
        .rw_rdata(sp_rw_rdata), .ro_addr(ro_addr), .ro_rdata(sp_ro_rdata));

    task automatic cmp(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        if (valid[rw_addr]) begin
            cmp(tag, rw_rdata, model[rw_addr]);
            cmp({tag, " R9 sp"}, sp_rw_rdata, model[rw_addr]);
        end
        if (valid[ro_addr]) cmp(tag, ro_rdata, model[ro_addr]);
        cmp("R9", sp_ro_rdata, 2'd0);
    endtask

    task automatic step(input string tag, input logic r, input logic we,
                        input logic [3:0] wa, input logic [1:0] wd, input logic [3:0] ra);
        @(negedge clk);
        rst = r; wr_en = we; rw_addr = wa; wr_data = wd; ro_addr = ra;
        #5;
        compare_all(tag);
        @(posedge clk);
        if (we && !r) begin
            model[wa] = wd;
            valid[wa] = 1'b1;
        end
        #2;
        compare_all(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) valid[i] = 1'b0;
        // reset state: single-port read-only output is zero (R9)
        step("R9 reset", 1'b1, 1'b0, 4'd0, 2'd0, 4'd0);
        cmp("R9 reset", sp_ro_rdata, 2'd0);
        step("R8 reset", 1'b1, 1'b1, 4'd3, 2'd1, 4'd3);
        // R1 and R5: fill with read-only port watching the written word
        for (int i = 0; i < 16; i++) step("R1 R5 fill", 1'b0, 1'b1, 4'(i), 2'(i ^ (i >> 2)), 4'(i));
        // R2 R3: opposite sweeps, no writes
        for (int i = 0; i < 16; i++) step("R2 R3 sweep", 1'b0, 1'b0, 4'(i), 2'd3, 4'(15 - i));
        // R5: overwrite watched word, old before edge, new after
        step("R5 overwrite", 1'b0, 1'b1, 4'd6, ~model[6], 4'd6);
        step("R5 overwrite", 1'b0, 1'b1, 4'd9, ~model[9], 4'd9);
        // R6: write one word while reading another
        step("R6 other", 1'b0, 1'b1, 4'd2, ~model[2], 4'd11);
        step("R6 other", 1'b0, 1'b0, 4'd11, 2'd0, 4'd2);
        // R7: enable low
        step("R7 no_en", 1'b0, 1'b0, 4'd4, ~model[4], 4'd4);
        step("R7 no_en", 1'b0, 1'b0, 4'd4, 2'd0, 4'd4);
        // R8: reset blocks write
        step("R8 rst_block", 1'b1, 1'b1, 4'd5, ~model[5], 4'd5);
        step("R8 rst_block", 1'b0, 1'b0, 4'd5, 2'd0, 4'd5);
        // R4: random traffic
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R4 random", 1'b0, lfsr[0], lfsr[4:1], lfsr[6:5],
                 lfsr[7] ? lfsr[4:1] : lfsr[11:8]);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule